// File: doc/BRIEF.md
# Flag-setting integer add/subtract ALU

This block is the add/subtract and single-bit datapath of a small RISC core. In one combinational step it takes the destination operand (RN), the source operand (RM), a 5-bit immediate field, the current carry flag and an operation select. It returns the result word, a write-enable for the destination register and the next Z, N and C flags. Each flag has its own update enable, so the core's flag register changes only the flags that an operation defines.

Every arithmetic operation goes through one shared adder. Subtraction is done as addition of the inverted operand, and C then reports a borrow, not a carry. Quick forms take their operand from the immediate field. Add-quick and subtract-quick read a field value of 0 as 32. Compare-quick sign-extends the field. Compare operations set the flags and leave the destination register alone. Bit-set and bit-clear leave C as it was.

The inputs and outputs are plain combinational signals, not a valid/ready stream. All of them belong to a single instruction in a single cycle, so there is no back-pressure to manage. The core around the block registers the result and the flags.

Top module: `addsub_flag_alu`

## Requirements
- R1: Whenever z_upd_o is 1, z_o is 1 exactly when result_o is zero. Whenever n_upd_o is 1, n_o equals result_o bit 31. When an update enable is 0, the matching flag output is 0.
- R2: ADD (op 1) gives result RN+RM modulo 2^32 and sets wr_en_o. It updates Z, N and C, with C equal to the unsigned carry-out of the 32-bit sum.
- R3: ADDC (op 2) gives result RN+RM+c_i modulo 2^32. C is the carry-out of adding RM to the 32-bit wrapped value (RN+c_i). Because of this, RN=FFFFFFFF with c_i=1 always gives C=0.
- R4: SUB (op 4) gives result RN-RM modulo 2^32 and sets wr_en_o. C is 1 exactly when unsigned RM is greater than unsigned RN, so C acts as a borrow.
- R5: SUBC (op 5) gives result RN-RM-c_i modulo 2^32. C is 1 exactly when the exact difference RN-RM-c_i is negative. This includes 0-0 with c_i=1 and FFFFFFFF-FFFFFFFF with c_i=1, which both give C=1.
- R6: ADDQ (op 3) and SUBQ (op 6) use the immediate as their second operand. Field value 0 means 32, and field values 1 to 31 mean themselves. Carry and borrow follow the rules of R2 and R4.
- R7: CMP (op 7) subtracts RM from RN. CMPQ (op 8) subtracts the sign-extended immediate (-16 to +15) from RN. Both put the difference on result_o and set Z, N and C as SUB does, but keep wr_en_o at 0.
- R8: NEG (op 9) gives result 0-RN and sets wr_en_o. It updates Z, N and C, and C is 1 exactly when RN is nonzero.
- R9: BSET (op 10) forces bit imm_i of RN to 1, and BCLR (op 11) forces it to 0. Both write the result back and update Z and N only. c_upd_o stays 0 and c_o equals c_i.
- R10: Op 0 and ops 12 to 15 do nothing. All enables are 0, result_o is 0, and c_o equals c_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rn_i | input | 32 | Destination register operand |
| rm_i | input | 32 | Source register operand |
| imm_i | input | 5 | Immediate field (quick operand or bit index) |
| c_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation select |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Write the result to the destination register |
| z_o | output | 1 | Next zero flag |
| n_o | output | 1 | Next negative flag |
| c_o | output | 1 | Next carry/borrow flag |
| z_upd_o | output | 1 | Zero flag update enable |
| n_upd_o | output | 1 | Negative flag update enable |
| c_upd_o | output | 1 | Carry flag update enable |

## Verification
Every output is a combinational function of the inputs of the same cycle, so each result is due zero clock cycles after its stimulus. The bench applies a new operand set one time unit after a rising edge. It compares all outputs against its 64-bit reference model at the following falling edge, when the logic has settled. The stimulus covers every operation code, including the unused ones. It uses all pairs of the corner values 0, 1, 7FFFFFFF, 80000000 and FFFFFFFF with both carry-in values, then sweeps every immediate value for the quick and bit forms, then runs random operands.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_ADDC = 4'd2,
    OP_ADDQ = 4'd3,
    OP_SUB  = 4'd4,
    OP_SUBC = 4'd5,
    OP_SUBQ = 4'd6,
    OP_CMP  = 4'd7,
    OP_CMPQ = 4'd8,
    OP_NEG  = 4'd9,
    OP_BSET = 4'd10,
    OP_BCLR = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    UNIT_NONE  = 2'd0,
    UNIT_ARITH = 2'd1,
    UNIT_BIT   = 2'd2
  } unit_e;

  typedef enum logic [1:0] {
    BSEL_RM      = 2'd0,
    BSEL_QUICK_U = 2'd1,
    BSEL_QUICK_S = 2'd2,
    BSEL_RN      = 2'd3
  } bsel_e;

  typedef struct packed {
    unit_e unit;
    bsel_e bsel;
    logic  sub;
    logic  pre_inc;
    logic  cin_flag;
    logic  a_zero;
    logic  wr;
    logic  bit_set;
  } alu_ctl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [3:0] op_i,
  output alu_ctl_t   ctl_o
);

  always_comb begin
    ctl_o = '{unit: UNIT_NONE, bsel: BSEL_RM, sub: 1'b0, pre_inc: 1'b0,
              cin_flag: 1'b0, a_zero: 1'b0, wr: 1'b0, bit_set: 1'b0};
    case (alu_op_e'(op_i))
      OP_ADD:  begin ctl_o.unit = UNIT_ARITH; ctl_o.wr = 1'b1; end
      OP_ADDC: begin ctl_o.unit = UNIT_ARITH; ctl_o.wr = 1'b1; ctl_o.pre_inc = 1'b1; end
      OP_ADDQ: begin ctl_o.unit = UNIT_ARITH; ctl_o.wr = 1'b1; ctl_o.bsel = BSEL_QUICK_U; end
      OP_SUB:  begin ctl_o.unit = UNIT_ARITH; ctl_o.wr = 1'b1; ctl_o.sub = 1'b1; end
      OP_SUBC: begin
        ctl_o.unit = UNIT_ARITH; ctl_o.wr = 1'b1; ctl_o.sub = 1'b1; ctl_o.cin_flag = 1'b1;
      end
      OP_SUBQ: begin
        ctl_o.unit = UNIT_ARITH; ctl_o.wr = 1'b1; ctl_o.sub = 1'b1; ctl_o.bsel = BSEL_QUICK_U;
      end
      OP_CMP:  begin ctl_o.unit = UNIT_ARITH; ctl_o.sub = 1'b1; end
      OP_CMPQ: begin ctl_o.unit = UNIT_ARITH; ctl_o.sub = 1'b1; ctl_o.bsel = BSEL_QUICK_S; end
      OP_NEG:  begin
        ctl_o.unit = UNIT_ARITH; ctl_o.wr = 1'b1; ctl_o.sub = 1'b1;
        ctl_o.a_zero = 1'b1; ctl_o.bsel = BSEL_RN;
      end
      OP_BSET: begin ctl_o.unit = UNIT_BIT; ctl_o.wr = 1'b1; ctl_o.bit_set = 1'b1; end
      OP_BCLR: begin ctl_o.unit = UNIT_BIT; ctl_o.wr = 1'b1; end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
  import alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 5
) (
  input  logic [W-1:0]     rn_i,
  input  logic [W-1:0]     rm_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             c_i,
  input  alu_ctl_t         ctl_i,
  output logic [W-1:0]     a_o,
  output logic [W-1:0]     b_o,
  output logic             cin_o
);

  localparam logic [W-1:0] QUICK_ZERO = W'(64'd1 << IMM_W);

  logic [W-1:0] quick_u;
  logic [W-1:0] quick_s;
  logic [W-1:0] a_base;
  logic [W-1:0] b_raw;

  assign quick_u = (imm_i == '0) ? QUICK_ZERO : W'(imm_i);
  assign quick_s = {{(W-IMM_W){imm_i[IMM_W-1]}}, imm_i};

  assign a_base = ctl_i.a_zero ? '0 : rn_i;
  assign a_o    = ctl_i.pre_inc ? (a_base + W'(c_i)) : a_base;

  always_comb begin
    case (ctl_i.bsel)
      BSEL_QUICK_U: b_raw = quick_u;
      BSEL_QUICK_S: b_raw = quick_s;
      BSEL_RN:      b_raw = rn_i;
      default:      b_raw = rm_i;
    endcase
  end

  assign b_o   = ctl_i.sub ? ~b_raw : b_raw;
  assign cin_o = ctl_i.sub & ~(ctl_i.cin_flag & c_i);

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  logic [W:0] full;

  assign full   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];

endmodule

// File: rtl/alu_bitop.sv
module alu_bitop #(
  parameter int W     = 32,
  parameter int IMM_W = 5
) (
  input  logic [W-1:0]     rn_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             set_i,
  output logic [W-1:0]     res_o
);

  logic [W-1:0] mask;

  for (genvar g = 0; g < W; g++) begin : g_mask
    assign mask[g] = ((int'(imm_i) % W) == g);
  end

  assign res_o = set_i ? (rn_i | mask) : (rn_i & ~mask);

endmodule

// File: rtl/addsub_flag_alu.sv
module addsub_flag_alu
  import alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 5
) (
  input  logic [W-1:0]     rn_i,
  input  logic [W-1:0]     rm_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             c_i,
  input  logic [3:0]       op_i,
  output logic [W-1:0]     result_o,
  output logic             wr_en_o,
  output logic             z_o,
  output logic             n_o,
  output logic             c_o,
  output logic             z_upd_o,
  output logic             n_upd_o,
  output logic             c_upd_o
);

  alu_ctl_t     ctl;
  logic [W-1:0] opa, opb, sum, bit_res;
  logic         add_cin, cout, carry_flag;

  alu_decode u_dec (.op_i(op_i), .ctl_o(ctl));

  alu_operand_sel #(.W(W), .IMM_W(IMM_W)) u_sel (
    .rn_i(rn_i), .rm_i(rm_i), .imm_i(imm_i), .c_i(c_i), .ctl_i(ctl),
    .a_o(opa), .b_o(opb), .cin_o(add_cin)
  );

  alu_adder #(.W(W)) u_add (
    .a_i(opa), .b_i(opb), .cin_i(add_cin), .sum_o(sum), .cout_o(cout)
  );

  alu_bitop #(.W(W), .IMM_W(IMM_W)) u_bit (
    .rn_i(rn_i), .imm_i(imm_i), .set_i(ctl.bit_set), .res_o(bit_res)
  );

  assign carry_flag = ctl.sub ? ~cout : cout;

  always_comb begin
    case (ctl.unit)
      UNIT_ARITH: result_o = sum;
      UNIT_BIT:   result_o = bit_res;
      default:    result_o = '0;
    endcase
  end

  assign wr_en_o = ctl.wr;
  assign z_upd_o = (ctl.unit != UNIT_NONE);
  assign n_upd_o = (ctl.unit != UNIT_NONE);
  assign c_upd_o = (ctl.unit == UNIT_ARITH);

  assign z_o = z_upd_o & (result_o == '0);
  assign n_o = n_upd_o & result_o[W-1];
  assign c_o = c_upd_o ? carry_flag : c_i;

endmodule

// File: rtl/alu_flag_checker.sv
module alu_flag_checker #(
  parameter int W = 32
) (
  input logic [W-1:0] rn_i,
  input logic         c_i,
  input logic [3:0]   op_i,
  input logic [W-1:0] result_o,
  input logic         wr_en_o,
  input logic         z_o,
  input logic         n_o,
  input logic         c_o,
  input logic         z_upd_o,
  input logic         n_upd_o,
  input logic         c_upd_o
);

  always_comb begin
    if (z_upd_o) begin
      assert_zero_flag_R1: assert (z_o == (result_o == '0));
    end
    if (n_upd_o) begin
      assert_neg_flag_R1: assert (n_o == result_o[W-1]);
    end
    if (op_i == 4'd7 || op_i == 4'd8) begin
      assert_cmp_no_write_R7: assert (!wr_en_o && c_upd_o && z_upd_o);
    end
    if (op_i == 4'd9) begin
      assert_neg_borrow_R8: assert (c_o == (rn_i != '0));
    end
    if (op_i == 4'd10 || op_i == 4'd11) begin
      assert_bit_keeps_c_R9: assert (!c_upd_o && c_o == c_i && wr_en_o);
    end
    if (op_i == 4'd0 || op_i > 4'd11) begin
      assert_idle_quiet_R10: assert (!wr_en_o && !z_upd_o && !n_upd_o && !c_upd_o
                                     && result_o == '0 && c_o == c_i);
    end
  end

endmodule

bind addsub_flag_alu alu_flag_checker #(.W(W)) u_chk (
  .rn_i(rn_i), .c_i(c_i), .op_i(op_i), .result_o(result_o), .wr_en_o(wr_en_o),
  .z_o(z_o), .n_o(n_o), .c_o(c_o), .z_upd_o(z_upd_o), .n_upd_o(n_upd_o),
  .c_upd_o(c_upd_o)
);

// File: tb/sim_addsub_flag_alu.sv
module sim_addsub_flag_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] rn, rm;
  logic [4:0]  imm;
  logic        cin;
  logic [3:0]  op;
  logic [31:0] result;
  logic        wr_en, z, n, c, z_upd, n_upd, c_upd;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  addsub_flag_alu u0 (
    .rn_i(rn), .rm_i(rm), .imm_i(imm), .c_i(cin), .op_i(op),
    .result_o(result), .wr_en_o(wr_en), .z_o(z), .n_o(n), .c_o(c),
    .z_upd_o(z_upd), .n_upd_o(n_upd), .c_upd_o(c_upd)
  );

  localparam longint unsigned M32 = 64'hFFFF_FFFF;
  logic [31:0] corners [5] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3, 4'd6: return "R6";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd7, 4'd8: return "R7";
      4'd9: return "R8";
      4'd10, 4'd11: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic compare();
    longint unsigned a = 64'(rn);
    longint unsigned b = 64'(rm);
    longint unsigned ci = 64'(cin);
    longint unsigned q = (imm == 5'd0) ? 64'd32 : 64'(imm);
    longint unsigned sq = imm[4] ? ((64'(imm) | ~64'd31) & M32) : 64'(imm);
    longint unsigned s, r;
    logic e_wr, e_zu, e_nu, e_cu, e_c, e_z, e_n;
    r = 0; e_wr = 0; e_zu = 0; e_nu = 0; e_cu = 0; e_c = cin;
    case (op)
      4'd1: begin s = a + b; r = s & M32; e_c = s[32]; e_wr = 1; e_cu = 1; end
      4'd2: begin s = ((a + ci) & M32) + b; r = (a + b + ci) & M32; e_c = s[32]; e_wr = 1; e_cu = 1; end
      4'd3: begin s = a + q; r = s & M32; e_c = s[32]; e_wr = 1; e_cu = 1; end
      4'd4: begin r = (a - b) & M32; e_c = b > a; e_wr = 1; e_cu = 1; end
      4'd5: begin r = (a - b - ci) & M32; e_c = (b + ci) > a; e_wr = 1; e_cu = 1; end
      4'd6: begin r = (a - q) & M32; e_c = q > a; e_wr = 1; e_cu = 1; end
      4'd7: begin r = (a - b) & M32; e_c = b > a; e_cu = 1; end
      4'd8: begin r = (a - sq) & M32; e_c = sq > a; e_cu = 1; end
      4'd9: begin r = (0 - a) & M32; e_c = a != 0; e_wr = 1; e_cu = 1; end
      4'd10: begin r = a | (64'd1 << imm); e_wr = 1; end
      4'd11: begin r = a & ~(64'd1 << imm) & M32; e_wr = 1; end
      default: ;
    endcase
    if (op >= 4'd1 && op <= 4'd11) begin e_zu = 1; e_nu = 1; end
    e_z = e_zu && (r == 0);
    e_n = e_nu && r[31];
    checks++;
    if (result !== r[31:0] || wr_en !== e_wr || z_upd !== e_zu || n_upd !== e_nu ||
        c_upd !== e_cu || c !== e_c || z !== e_z || n !== e_n) begin
      fails++;
      $display("FAIL %s (R1 flags) op=%0d rn=%h rm=%h imm=%0d c_in=%b: got res=%h wr=%b zn c=%b%b%b upd=%b%b%b exp res=%h wr=%b zn c=%b%b%b upd=%b%b%b",
               tag(op), op, rn, rm, imm, cin, result, wr_en, z, n, c, z_upd, n_upd, c_upd,
               r[31:0], e_wr, e_z, e_n, e_c, e_zu, e_nu, e_cu);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic [4:0] i, input logic ci);
    @(posedge clk);
    #1;
    op = o; rn = x; rm = y; imm = i; cin = ci;
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    op = 4'd0; rn = 32'hDEAD_BEEF; rm = 32'h1234_5678; imm = 5'd3; cin = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare();  // reset phase, idle op: R10
    rst = 1'b0;

    // R5 borrow-in corner cases
    apply(4'd5, 32'h0, 32'h0, 5'd0, 1'b1);
    apply(4'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 1'b1);
    // R3 wrapped pre-increment
    apply(4'd2, 32'hFFFF_FFFF, 32'h0000_0005, 5'd0, 1'b1);

    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          for (int k = 0; k < 2; k++)
            apply(4'(o), corners[i], corners[j], 5'($urandom), 1'(k));

    // immediate sweep for quick and bit forms (R6, R7, R9)
    for (int v = 0; v < 32; v++)
      for (int i = 0; i < 5; i++) begin
        apply(4'd3, corners[i], 32'h0, 5'(v), 1'b0);
        apply(4'd6, corners[i], 32'h0, 5'(v), 1'b1);
        apply(4'd8, corners[i], 32'h0, 5'(v), 1'b0);
        apply(4'd10, corners[i], 32'h0, 5'(v), 1'b1);
        apply(4'd11, corners[i], 32'h0, 5'(v), 1'b0);
      end

    for (int t = 0; t < 3000; t++)
      apply(4'($urandom_range(0, 15)), $urandom, $urandom, 5'($urandom), 1'($urandom));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule